// File: doc/BRIEF.md
# Single-Wire ROM Command Slave

This block is the addressing layer of a slave on a single-wire, open-drain bus. A link layer turns analog slot timing into two events: a bus-reset event, and a slot strobe that carries the sampled line value. After each bus reset the block collects an 8-bit ROM command. It then acts on that command, bit by bit, against a fixed 64-bit identity that is built from parameters. When addressing succeeds it raises a selected flag, and a memory-function layer takes over from there. When addressing fails it goes quiet until the next bus reset.

The block supports four commands. Read-identity sends all 64 identity bits. Match-identity compares 64 received bits against the identity. Skip-addressing selects the slave at once. Search takes part in the bit-pair arbitration. In each search step the block sends its bit, then the complement of that bit, then reads the direction the master chose. It drops out on the first disagreement. Several slaves that send at the same time produce a wired-AND of their bits, and the search step resolves that collision.

Top module: `rom_cmd_slave`

## Requirements
- R1: After `rst_n` falls, `selected_o`=0, `drive_low_o`=0 and `tx_bit_o`=1. Slot strobes are then ignored until the first bus-reset event.
- R2: A bus-reset event restarts command reception in any state and clears `selected_o`. It takes priority over a slot strobe in the same cycle.
- R3: The 8 strobes that follow a bus reset build the command, least significant bit first. Nothing is driven while the command is collected.
- R4: Command 33h sends the identity over the next 64 slots. Before slot i, `tx_bit_o` equals identity bit i, starting at bit 0, and `drive_low_o` is its inverse. After the 64th slot, `selected_o` rises.
- R5: The identity holds the family code in bits 7:0, the serial number in bits 55:8, and a check byte in bits 63:56. With default parameters, the check byte is a CRC-8 over bits 55:0, fed LSB first, with polynomial x^8+x^5+x^4+1 and an initial value of 0.
- R6: Command 55h compares the next 64 received bits with the identity. If all 64 agree, `selected_o` rises. On any difference the block stays unselected and quiet until a bus reset.
- R7: Command CCh raises `selected_o` on the strobe that completes the command.
- R8: Command F0h handles each identity bit in three slots. The block sends the bit, then its complement, then reads the master's direction. `drive_low_o` is high exactly when the value being sent is 0.
- R9: In search, a direction that differs from the identity bit ends participation until a bus reset. If all 64 directions agree, `selected_o` rises.
- R10: Any other command code leaves the block unselected, with nothing driven, until a bus reset.
- R11: While selected or out of the transaction, slot strobes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle bus reset/presence event from the link layer |
| slot_strobe_i | input | 1 | One-cycle marker that a bit slot completed |
| slot_bit_i | input | 1 | Line value sampled in the completed slot |
| tx_bit_o | output | 1 | Value the slave sends in the coming slot, 1 when releasing |
| drive_low_o | output | 1 | Request to pull the line low in the coming slot |
| selected_o | output | 1 | Addressing succeeded, memory layer may proceed |

## Verification
The assertions assume that `bus_reset_i` and `slot_strobe_i` are single-cycle pulses from a link layer. They also assume that `slot_bit_i` is the wired-AND line value, so it is 0 whenever this slave asked to drive low. The stimulus holds each strobe for exactly one clock with idle clocks between strobes. It derives every sampled bit from the block's own drive request, combined with an emulated master or a second emulated slave. One case raises a bus reset together with a strobe to test the stated priority.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;

   typedef enum logic [2:0] {
      ST_WAIT   = 3'd0,
      ST_CMD    = 3'd1,
      ST_READ   = 3'd2,
      ST_MATCH  = 3'd3,
      ST_SEARCH = 3'd4,
      ST_SEL    = 3'd5,
      ST_DORM   = 3'd6
   } rom_state_t;

   typedef enum logic [1:0] {
      PH_BIT = 2'd0,
      PH_CMP = 2'd1,
      PH_DIR = 2'd2
   } srch_phase_t;

endpackage

// File: rtl/rom_slot_counter.sv
module rom_slot_counter #(
   parameter int CNT_W = 6,
   parameter int LAST  = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);

   if (LAST < 1 || LAST >= (1 << CNT_W)) begin : g_bad_last
      $error("rom_slot_counter: LAST does not fit CNT_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_o <= '0;
      else if (clr_i)          cnt_o <= '0;
      else if (inc_i) begin
         if (cnt_o == LAST_V)  cnt_o <= '0;
         else                  cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/rom_cmd_shreg.sv
module rom_cmd_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] next_o
);
   logic [W-1:0] word_q;

   if (W < 2) begin : g_bad_w
      $error("rom_cmd_shreg: W must be at least 2");
   end

   // first bit received ends in bit 0 after W shifts
   assign next_o = {bit_i, word_q[W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (clr_i)    word_q <= '0;
      else if (shift_i)  word_q <= next_o;
   end
endmodule

// File: rtl/rom_id_source.sv
module rom_id_source #(
   parameter int                FAM_W   = 8,
   parameter int                SER_W   = 48,
   parameter int                CRC_W   = 8,
   parameter logic [FAM_W-1:0]  FAMILY  = '0,
   parameter logic [SER_W-1:0]  SERIAL  = '0,
   parameter bit                CRC_GEN = 1'b1,
   parameter logic [CRC_W-1:0]  CRC_VAL = '0,
   localparam int               BODY_W  = FAM_W + SER_W,
   localparam int               ID_W    = BODY_W + CRC_W
) (
   output logic [ID_W-1:0] id_o
);
   localparam logic [BODY_W-1:0] BODY = {SERIAL, FAMILY};

   function automatic logic [7:0] crc8_body(input logic [BODY_W-1:0] d);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 0; i < BODY_W; i++) begin
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   logic [CRC_W-1:0] check_byte;

   if (CRC_GEN) begin : g_crc_calc
      if (CRC_W != 8) begin : g_bad_crc
         $error("rom_id_source: computed check needs CRC_W of 8");
      end
      assign check_byte = CRC_W'(crc8_body(BODY));
   end else begin : g_crc_fixed
      assign check_byte = CRC_VAL;
   end

   assign id_o = {check_byte, BODY};
endmodule

// File: rtl/rom_cmd_slave.sv
module rom_cmd_slave
   import rom_cmd_pkg::*;
#(
   parameter int                FAM_W     = 8,
   parameter int                SER_W     = 48,
   parameter int                CRC_W     = 8,
   parameter logic [FAM_W-1:0]  FAMILY    = 8'h2D,
   parameter logic [SER_W-1:0]  SERIAL    = 48'h5E1234ABCD70,
   parameter bit                CRC_GEN   = 1'b1,
   parameter logic [CRC_W-1:0]  CRC_VAL   = '0,
   parameter int                CMD_W     = 8,
   parameter logic [CMD_W-1:0]  OP_READ   = 8'h33,
   parameter logic [CMD_W-1:0]  OP_MATCH  = 8'h55,
   parameter logic [CMD_W-1:0]  OP_SKIP   = 8'hCC,
   parameter logic [CMD_W-1:0]  OP_SEARCH = 8'hF0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_reset_i,
   input  logic slot_strobe_i,
   input  logic slot_bit_i,
   output logic tx_bit_o,
   output logic drive_low_o,
   output logic selected_o
);
   localparam int ID_W      = FAM_W + SER_W + CRC_W;
   localparam int IDX_W     = $clog2(ID_W);
   localparam int CMD_CNT_W = $clog2(CMD_W);
   localparam logic [IDX_W-1:0]     ID_LAST  = IDX_W'(ID_W - 1);
   localparam logic [CMD_CNT_W-1:0] CMD_LAST = CMD_CNT_W'(CMD_W - 1);

   if (FAM_W < 1 || SER_W < 1 || CRC_W < 1) begin : g_bad_fields
      $error("rom_cmd_slave: identity fields must be non-empty");
   end
   if (CMD_W < 2) begin : g_bad_cmd
      $error("rom_cmd_slave: command width too small");
   end
   if (OP_READ == OP_MATCH || OP_READ == OP_SKIP || OP_READ == OP_SEARCH ||
       OP_MATCH == OP_SKIP || OP_MATCH == OP_SEARCH || OP_SKIP == OP_SEARCH) begin : g_bad_ops
      $error("rom_cmd_slave: command codes must differ");
   end

   rom_state_t  state_q, state_d;
   srch_phase_t phase_q, phase_d;

   logic [ID_W-1:0]      id_vec;
   logic [IDX_W-1:0]     id_idx;
   logic [CMD_CNT_W-1:0] cmd_cnt;
   logic [CMD_W-1:0]     cmd_next;
   logic                 id_bit, id_last, cmd_last;
   logic                 live_strobe, cmd_inc, id_inc;
   logic                 send_en, send_val;

   rom_id_source #(
      .FAM_W(FAM_W), .SER_W(SER_W), .CRC_W(CRC_W),
      .FAMILY(FAMILY), .SERIAL(SERIAL),
      .CRC_GEN(CRC_GEN), .CRC_VAL(CRC_VAL)
   ) u_id (
      .id_o(id_vec)
   );

   assign live_strobe = slot_strobe_i && !bus_reset_i;
   assign cmd_inc     = live_strobe && (state_q == ST_CMD);
   assign id_inc      = live_strobe && ((state_q == ST_READ) || (state_q == ST_MATCH) ||
                        ((state_q == ST_SEARCH) && (phase_q == PH_DIR)));

   rom_slot_counter #(.CNT_W(CMD_CNT_W), .LAST(CMD_W - 1)) u_cmd_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(bus_reset_i), .inc_i(cmd_inc), .cnt_o(cmd_cnt)
   );

   rom_slot_counter #(.CNT_W(IDX_W), .LAST(ID_W - 1)) u_id_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(bus_reset_i), .inc_i(id_inc), .cnt_o(id_idx)
   );

   rom_cmd_shreg #(.W(CMD_W)) u_cmd_sr (
      .clk(clk), .rst_n(rst_n), .clr_i(bus_reset_i), .shift_i(cmd_inc),
      .bit_i(slot_bit_i), .next_o(cmd_next)
   );

   assign id_bit   = id_vec[id_idx];
   assign id_last  = (id_idx == ID_LAST);
   assign cmd_last = (cmd_cnt == CMD_LAST);

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      if (bus_reset_i) begin
         state_d = ST_CMD;
         phase_d = PH_BIT;
      end else if (slot_strobe_i) begin
         unique case (state_q)
            ST_CMD: begin
               if (cmd_last) begin
                  phase_d = PH_BIT;
                  if      (cmd_next == OP_READ)   state_d = ST_READ;
                  else if (cmd_next == OP_MATCH)  state_d = ST_MATCH;
                  else if (cmd_next == OP_SKIP)   state_d = ST_SEL;
                  else if (cmd_next == OP_SEARCH) state_d = ST_SEARCH;
                  else                            state_d = ST_DORM;
               end
            end
            ST_READ: begin
               if (id_last) state_d = ST_SEL;
            end
            ST_MATCH: begin
               if (slot_bit_i != id_bit) state_d = ST_DORM;
               else if (id_last)         state_d = ST_SEL;
            end
            ST_SEARCH: begin
               unique case (phase_q)
                  PH_BIT: phase_d = PH_CMP;
                  PH_CMP: phase_d = PH_DIR;
                  default: begin
                     phase_d = PH_BIT;
                     if (slot_bit_i != id_bit) state_d = ST_DORM;
                     else if (id_last)         state_d = ST_SEL;
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         phase_q <= PH_BIT;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
      end
   end

   assign send_en  = (state_q == ST_READ) || ((state_q == ST_SEARCH) && (phase_q != PH_DIR));
   assign send_val = ((state_q == ST_SEARCH) && (phase_q == PH_CMP)) ? !id_bit : id_bit;

   assign tx_bit_o    = send_en ? send_val : 1'b1;
   assign drive_low_o = send_en && !send_val;
   assign selected_o  = (state_q == ST_SEL);

   // R1
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |-> (!drive_low_o && !selected_o && tx_bit_o));

   // R2
   bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (!selected_o && !drive_low_o));

   // R3
   cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMD) |-> (!drive_low_o && !selected_o));

   // R4
   drive_matches_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low_o |-> !tx_bit_o);

   // R8
   search_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && phase_q == PH_BIT && live_strobe) |=>
         (tx_bit_o == !$past(tx_bit_o)));

   // R10
   dormant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DORM && !bus_reset_i) |=> (!drive_low_o && !selected_o));

   // R11
   selected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selected_o && !bus_reset_i) |=> selected_o);

endmodule

// File: tb/tb_rom_cmd_slave.sv
`timescale 1ns/1ps
module tb_rom_cmd_slave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset_i = 1'b0;
   logic slot_strobe_i = 1'b0;
   logic slot_bit_i = 1'b0;
   logic tx_bit_o, drive_low_o, selected_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [7:0]  FAM = 8'h2D;
   localparam logic [47:0] SER = 48'h5E1234ABCD70;

   logic [63:0] eid;

   always #4 clk = ~clk;

   rom_cmd_slave #(.FAMILY(FAM), .SERIAL(SER)) dut (
      .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
      .slot_strobe_i(slot_strobe_i), .slot_bit_i(slot_bit_i),
      .tx_bit_o(tx_bit_o), .drive_low_o(drive_low_o), .selected_o(selected_o)
   );

   function automatic logic [7:0] ref_crc(input logic [55:0] d);
      logic [7:0] c = 8'h00;
      for (int b = 0; b < 7; b++) begin
         c = c ^ d[b*8 +: 8];
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference: 0 wait,1 cmd,2 read,3 match,4 search,5 selected,6 out
   int ms = 0, mi = 0, mp = 0, mc = 0;
   logic [7:0] mcmd = 8'h00;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms = 0; mi = 0; mp = 0; mc = 0; mcmd = 8'h00;
      end else if (bus_reset_i) begin
         ms = 1; mi = 0; mp = 0; mc = 0; mcmd = 8'h00;
      end else if (slot_strobe_i) begin
         case (ms)
            1: begin
               mcmd[mc] = slot_bit_i;
               mc++;
               if (mc == 8) begin
                  case (mcmd)
                     8'h33: ms = 2;
                     8'h55: ms = 3;
                     8'hCC: ms = 5;
                     8'hF0: begin ms = 4; mp = 0; end
                     default: ms = 6;
                  endcase
               end
            end
            2: if (mi == 63) ms = 5; else mi++;
            3: if (slot_bit_i != eid[mi]) ms = 6; else if (mi == 63) ms = 5; else mi++;
            4: if (mp < 2) mp++;
               else if (slot_bit_i != eid[mi]) ms = 6;
               else if (mi == 63) ms = 5;
               else begin mi++; mp = 0; end
            default: ;
         endcase
      end
   end

   function automatic string tag_of(input int s);
      case (s)
         0: return "R1";
         1: return "R3";
         2: return "R4";
         3: return "R6";
         4: return "R8";
         5: return "R11";
         default: return "R10";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic snd, val;
         snd = (ms == 2) || (ms == 4 && mp < 2);
         val = (ms == 4 && mp == 1) ? ~eid[mi] : eid[mi];
         chk(tag_of(ms), {61'd0, tx_bit_o, drive_low_o, selected_o},
             {61'd0, (snd ? val : 1'b1), (snd & ~val), (ms == 5)});
      end
   end

   task automatic bus_rst();
      @(negedge clk); bus_reset_i = 1'b1;
      @(negedge clk); bus_reset_i = 1'b0;
   endtask

   task automatic wr_slot(input logic b);
      @(negedge clk); slot_strobe_i = 1'b1; slot_bit_i = b;
      @(negedge clk); slot_strobe_i = 1'b0;
   endtask

   // read slot: the line is the wired-AND of this slave and another source
   task automatic rd_slot(input logic other, output logic line);
      @(negedge clk);
      line = (drive_low_o ? 1'b0 : 1'b1) & other;
      slot_strobe_i = 1'b1; slot_bit_i = line;
      @(negedge clk); slot_strobe_i = 1'b0;
   endtask

   task automatic send_cmd(input logic [7:0] c);
      for (int i = 0; i < 8; i++) wr_slot(c[i]);
   endtask

   task automatic search_run(input logic [63:0] other, input bit other_on,
                             input int flip_at, output logic [63:0] path);
      bit oa = other_on;
      for (int i = 0; i < 64; i++) begin
         logic a, b, dir;
         rd_slot(oa ? other[i] : 1'b1, a);
         rd_slot(oa ? ~other[i] : 1'b1, b);
         if (!other_on && flip_at < 0) chk("R8 pair", {62'd0, a, b}, {62'd0, eid[i], ~eid[i]});
         dir = (a != b) ? a : 1'b0;
         if (i == flip_at) dir = ~dir;
         path[i] = dir;
         if (oa && other[i] != dir) oa = 1'b0;
         wr_slot(dir);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] got, other;
      logic l;
      int k_one, k_zero;
      eid = {8'h00, SER, FAM};
      eid[63:56] = ref_crc(eid[55:0]);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state and strobes before any bus reset
      chk("R1 reset", {61'd0, tx_bit_o, drive_low_o, selected_o}, 64'd4);
      for (int i = 0; i < 5; i++) wr_slot(1'b0);
      chk("R1 ignored", {63'd0, selected_o}, 64'd0);

      // R4/R5: read identity
      bus_rst(); send_cmd(8'h33);
      for (int i = 0; i < 64; i++) begin rd_slot(1'b1, l); got[i] = l; end
      chk("R5 identity", got, eid);
      chk("R4 selected", {63'd0, selected_o}, 64'd1);
      for (int i = 0; i < 6; i++) wr_slot(1'b0);
      chk("R11 hold", {63'd0, selected_o}, 64'd1);

      // R7: skip
      bus_rst(); send_cmd(8'hCC);
      chk("R7 skip", {63'd0, selected_o}, 64'd1);

      // R6: match good and bad
      bus_rst(); send_cmd(8'h55);
      for (int i = 0; i < 64; i++) wr_slot(eid[i]);
      chk("R6 match", {63'd0, selected_o}, 64'd1);
      bus_rst(); send_cmd(8'h55);
      got = eid ^ (64'd1 << 40);
      for (int i = 0; i < 64; i++) wr_slot(got[i]);
      chk("R6 mismatch", {62'd0, selected_o, drive_low_o}, 64'd0);

      // R8/R9: clean search, then forced wrong direction
      bus_rst(); send_cmd(8'hF0);
      search_run(64'd0, 1'b0, -1, got);
      chk("R9 path", got, eid);
      chk("R9 selected", {63'd0, selected_o}, 64'd1);
      bus_rst(); send_cmd(8'hF0);
      search_run(64'd0, 1'b0, 20, got);
      chk("R9 dropout", {63'd0, selected_o}, 64'd0);

      // R9: wired-AND collision with a second slave
      k_one = -1; k_zero = -1;
      for (int i = 4; i < 64; i++) begin
         if (eid[i] && k_one < 0) k_one = i;
         if (!eid[i] && k_zero < 0) k_zero = i;
      end
      bus_rst(); send_cmd(8'hF0);
      other = eid ^ (64'd1 << k_one);
      search_run(other, 1'b1, -1, got);
      chk("R9 lose", {63'd0, selected_o}, 64'd0);
      bus_rst(); send_cmd(8'hF0);
      other = eid ^ (64'd1 << k_zero);
      search_run(other, 1'b1, -1, got);
      chk("R9 win", {63'd0, selected_o}, 64'd1);

      // R10: unknown command
      bus_rst(); send_cmd(8'h5A);
      for (int i = 0; i < 16; i++) begin rd_slot(1'b1, l); got[i] = l; end
      chk("R10 line", {48'd0, got[15:0]}, 64'h0000_0000_0000_FFFF);
      chk("R10 unselected", {63'd0, selected_o}, 64'd0);

      // R2: bus reset mid-read, together with a strobe
      bus_rst(); send_cmd(8'h33);
      for (int i = 0; i < 10; i++) rd_slot(1'b1, l);
      @(negedge clk); bus_reset_i = 1'b1; slot_strobe_i = 1'b1; slot_bit_i = 1'b0;
      @(negedge clk); bus_reset_i = 1'b0; slot_strobe_i = 1'b0;
      chk("R2 restart", {62'd0, selected_o, drive_low_o}, 64'd0);
      send_cmd(8'hCC);
      chk("R2 fresh cmd", {63'd0, selected_o}, 64'd1);
      bus_rst();
      chk("R2 clear", {63'd0, selected_o}, 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule